// File: doc/BRIEF.md
# Daisy-Chained Bus Mastership Requester

This block sits inside a peripheral that shares an asynchronous parallel bus with a central arbiter and other would-be masters. When local logic wants to move data, the block raises the bus request line. The arbiter answers on a grant chain that runs past every device in order of distance. Each device either keeps the grant for itself or hands it on to the next device. This block takes the grant only if it was already requesting at the moment the grant arrived. When it takes the grant, it drops its request and raises the acknowledge line. Any other grant is repeated on the chain output.

The grant input and the bus sync line belong to another timing domain, so both go through a synchronizer of parameter depth (`SYNC_STAGES`, 0 to 4). The choice to take or forward a grant is made once, on the synchronized rising edge of the grant. That choice is then held until the grant falls, so one grant can never be both taken and forwarded. After taking the grant, the block waits until the previous master has released sync. Only then does it tell local logic that it owns the bus. It gives the bus back when local logic signals done, or on its own once `MAX_BEATS` transfers have completed, so that refresh traffic cannot be starved. After a release the request stays low for `HOLDOFF` cycles. All ports are active high; conversion to the bus's electrical polarity is done outside the block.

Top module: `dma_chain_requester`

## Requirements
- R1: After `rst_n` is released, `bus_req_o`, `bus_ack_o`, `bus_own_o` and `grant_out_o` are all 0.
- R2: When `xfer_want_i` is 1 and the block is idle, `bus_req_o` rises at the next clock edge. It then stays 1 until a grant is taken, even if `xfer_want_i` drops.
- R3: A grant whose synchronized rising edge finds the block requesting is taken. The edge used is `SYNC_STAGES`+1 clock edges after `grant_in_i` rises. At that edge `bus_req_o` goes to 0 and `bus_ack_o` goes to 1 together. `grant_out_o` stays 0 for the whole of that grant.
- R4: A grant that finds the block not requesting is forwarded. `grant_out_o` follows `grant_in_i` with a delay of `SYNC_STAGES`+1 clock edges, on both the rising and the falling transition.
- R5: `bus_own_o` rises only while the synchronized `sync_busy_i` is 0. This happens one edge after the take if sync is already low. Otherwise it happens `SYNC_STAGES`+1 edges after `sync_busy_i` falls. `bus_own_o` is never 1 without `bus_ack_o`.
- R6: When `xfer_done_i` is 1 at an edge while the block owns the bus, `bus_ack_o` and `bus_own_o` both drop at that edge.
- R7: The edge that carries the `MAX_BEATS`-th `xfer_beat_i` pulse of one ownership releases the bus (`bus_ack_o` and `bus_own_o` go to 0), with no `xfer_done_i` needed. Fewer beats leave ownership in place.
- R8: After any release, `bus_req_o` stays 0 for `HOLDOFF` clock cycles, even while `xfer_want_i` is held at 1.
- R9: `bus_init_i` at a clock edge clears the request, acknowledge, ownership and forwarded grant at that edge, from any state.
- R10: A request raised while a grant is already high does not take that grant. The grant keeps being forwarded until it falls, and `bus_ack_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_init_i | input | 1 | Bus reset, synchronous to `clk`, active high |
| xfer_want_i | input | 1 | Local logic wants to become bus master |
| xfer_beat_i | input | 1 | One-cycle pulse per completed transfer while owning |
| xfer_done_i | input | 1 | Local logic gives the bus back |
| grant_in_i | input | 1 | Grant chain input from the device nearer the arbiter (asynchronous) |
| sync_busy_i | input | 1 | Bus sync line, 1 while some master holds a cycle (asynchronous) |
| grant_out_o | output | 1 | Grant chain output to the next device |
| bus_req_o | output | 1 | Bus request line |
| bus_ack_o | output | 1 | Acknowledge line, 1 while this device is the granted master |
| bus_own_o | output | 1 | Local indication that transfers may start |

## Verification
Each result has a fixed delay. Anything that starts at the grant or sync inputs becomes visible `SYNC_STAGES`+1 clock edges later. Ownership follows a take by one more edge when sync is already low. Request, release and bus reset each act at the first edge that samples them. The hold-off keeps the request low for exactly `HOLDOFF` edges. The bench drives inputs on the falling clock edge and counts rising edges up to the cycle where a change is due. For every delayed result it checks both the cycle just before the change (old value) and the cycle of the change (new value), so an output that comes one cycle early or late is reported.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

   // Mastership sequencing states
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,   // not asking for the bus
      ST_REQ  = 3'd1,   // request line raised, waiting for a grant edge
      ST_TAKE = 3'd2,   // grant taken, acknowledge up, waiting for sync release
      ST_OWN  = 3'd3,   // local logic may transfer
      ST_HOLD = 3'd4    // forced quiet time after giving the bus back
   } own_state_e;

endpackage

// File: rtl/dma_in_sync.sv
module dma_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] stage_q;
         for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) stage_q[i] <= 1'b0;
                  else        stage_q[i] <= d_i;
               end
            end else begin : g_next
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) stage_q[i] <= 1'b0;
                  else        stage_q[i] <= stage_q[i-1];
               end
            end
         end
         assign q_o = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/dma_grant_link.sv
module dma_grant_link (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic grant_s_i,   // synchronized grant
   input  logic take_i,      // owner logic claims the grant at this edge
   output logic rise_o,      // grant edge seen this cycle
   output logic grant_out_o
);

   logic gprev_q;
   logic pass_q;
   logic gout_q;

   assign rise_o = grant_s_i & ~gprev_q;

   // The take/forward choice is fixed at the grant edge and kept until the grant falls.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gprev_q <= 1'b0;
         pass_q  <= 1'b0;
         gout_q  <= 1'b0;
      end else if (clr_i) begin
         gprev_q <= grant_s_i;
         pass_q  <= 1'b0;
         gout_q  <= 1'b0;
      end else begin
         gprev_q <= grant_s_i;
         if (rise_o)          pass_q <= ~take_i;
         else if (!grant_s_i) pass_q <= 1'b0;
         gout_q <= grant_s_i & (rise_o ? ~take_i : pass_q);
      end
   end

   assign grant_out_o = gout_q;

endmodule

// File: rtl/dma_beat_limit.sv
module dma_beat_limit #(
   parameter int MAX_BEATS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,    // ownership in progress
   input  logic beat_i,
   output logic last_o       // this beat reaches the cap
);

   generate
      if (MAX_BEATS == 1) begin : g_single
         assign last_o = active_i & beat_i;
      end else begin : g_count
         localparam int CW = $clog2(MAX_BEATS + 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  cnt_q <= '0;
            else if (!active_i)          cnt_q <= '0;
            else if (beat_i && !last_o)  cnt_q <= cnt_q + 1'b1;
         end

         assign last_o = active_i & beat_i & (cnt_q == CW'(MAX_BEATS - 1));
      end
   endgenerate

endmodule

// File: rtl/dma_owner_fsm.sv
module dma_owner_fsm
   import dma_chain_pkg::*;
#(
   parameter int HOLDOFF = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic want_i,
   input  logic done_i,
   input  logic last_i,      // beat cap reached
   input  logic rise_i,      // synchronized grant edge
   input  logic sync_s_i,    // synchronized sync line
   output logic take_o,
   output logic own_active_o,
   output logic breq_o,
   output logic ack_o,
   output logic own_o
);

   localparam int HW = (HOLDOFF > 1) ? $clog2(HOLDOFF) : 1;

   own_state_e    st_q, st_n;
   logic [HW-1:0] hold_q, hold_n;
   logic          breq_q, ack_q, own_q;

   assign take_o       = (st_q == ST_REQ) & rise_i;
   assign own_active_o = (st_q == ST_OWN);

   always_comb begin
      st_n   = st_q;
      hold_n = '0;
      unique case (st_q)
         ST_IDLE: if (want_i) st_n = ST_REQ;
         ST_REQ:  if (rise_i) st_n = ST_TAKE;
         ST_TAKE: if (!sync_s_i) st_n = ST_OWN;
         ST_OWN:  if (done_i || last_i) st_n = ST_HOLD;
         ST_HOLD: begin
            if (hold_q == HW'(HOLDOFF - 1)) st_n = want_i ? ST_REQ : ST_IDLE;
            else                            hold_n = hold_q + 1'b1;
         end
         default: st_n = ST_IDLE;
      endcase
   end

   // Outputs registered straight from the next state so bus lines never glitch.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         hold_q <= '0;
         breq_q <= 1'b0;
         ack_q  <= 1'b0;
         own_q  <= 1'b0;
      end else if (clr_i) begin
         st_q   <= ST_IDLE;
         hold_q <= '0;
         breq_q <= 1'b0;
         ack_q  <= 1'b0;
         own_q  <= 1'b0;
      end else begin
         st_q   <= st_n;
         hold_q <= hold_n;
         breq_q <= (st_n == ST_REQ);
         ack_q  <= (st_n == ST_TAKE) || (st_n == ST_OWN);
         own_q  <= (st_n == ST_OWN);
      end
   end

   assign breq_o = breq_q;
   assign ack_o  = ack_q;
   assign own_o  = own_q;

endmodule

// File: rtl/dma_chain_requester.sv
module dma_chain_requester #(
   parameter int SYNC_STAGES = 2,
   parameter int MAX_BEATS   = 8,
   parameter int HOLDOFF     = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_init_i,
   input  logic xfer_want_i,
   input  logic xfer_beat_i,
   input  logic xfer_done_i,
   input  logic grant_in_i,
   input  logic sync_busy_i,
   output logic grant_out_o,
   output logic bus_req_o,
   output logic bus_ack_o,
   output logic bus_own_o
);

   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
      if (MAX_BEATS < 1) begin : g_bad_beats
         $error("MAX_BEATS must be at least 1");
      end
      if (HOLDOFF < 1) begin : g_bad_hold
         $error("HOLDOFF must be at least 1");
      end
   endgenerate

   logic grant_s;
   logic sync_s;
   logic rise;
   logic take;
   logic own_active;
   logic last_beat;

   dma_in_sync #(.STAGES(SYNC_STAGES)) u_grant_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (grant_in_i),
      .q_o   (grant_s)
   );

   dma_in_sync #(.STAGES(SYNC_STAGES)) u_busy_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (sync_busy_i),
      .q_o   (sync_s)
   );

   dma_grant_link u_link (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (bus_init_i),
      .grant_s_i   (grant_s),
      .take_i      (take),
      .rise_o      (rise),
      .grant_out_o (grant_out_o)
   );

   dma_beat_limit #(.MAX_BEATS(MAX_BEATS)) u_limit (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (own_active),
      .beat_i   (xfer_beat_i),
      .last_o   (last_beat)
   );

   dma_owner_fsm #(.HOLDOFF(HOLDOFF)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .clr_i        (bus_init_i),
      .want_i       (xfer_want_i),
      .done_i       (xfer_done_i),
      .last_i       (last_beat),
      .rise_i       (rise),
      .sync_s_i     (sync_s),
      .take_o       (take),
      .own_active_o (own_active),
      .breq_o       (bus_req_o),
      .ack_o        (bus_ack_o),
      .own_o        (bus_own_o)
   );

endmodule

// File: rtl/dma_chain_checker.sv
module dma_chain_checker #(
   parameter int MAX_BEATS = 8
) (
   input logic clk,
   input logic rst_n,
   input logic bus_init_i,
   input logic xfer_beat_i,
   input logic xfer_done_i,
   input logic grant_out_o,
   input logic bus_req_o,
   input logic bus_ack_o,
   input logic bus_own_o
);

   int unsigned beats_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      beats_seen <= 0;
      else if (!bus_own_o)             beats_seen <= 0;
      else if (xfer_beat_i)            beats_seen <= beats_seen + 1;
   end

   // R2: a raised request persists until taken or cleared
   p_req_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && !bus_init_i) |=> (bus_req_o || bus_ack_o));

   // R3: request and acknowledge never overlap
   p_req_ack_mutex_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_req_o && bus_ack_o));

   // R3: acknowledge rises exactly as the request drops, with no forwarded grant
   p_take_swap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_ack_o) |-> ($past(bus_req_o) && !bus_req_o && !grant_out_o));

   // R5: ownership implies acknowledge
   p_own_has_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_own_o |-> bus_ack_o);

   // R6: done while owning releases at once
   p_done_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_own_o && xfer_done_i) |=> (!bus_own_o && !bus_ack_o));

   // R7: never more than MAX_BEATS beats inside one ownership
   p_beat_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_own_o |-> (beats_seen < MAX_BEATS));

   // R8: no request in the cycle after a release
   p_holdoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_ack_o) |-> !bus_req_o);

   // R9: bus reset clears all lines
   p_init_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_init_i |=> (!bus_req_o && !bus_ack_o && !bus_own_o && !grant_out_o));

   // R10: never forward a grant while holding acknowledge from a take
   p_no_double_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_ack_o) |=> !$rose(grant_out_o));

endmodule

bind dma_chain_requester dma_chain_checker #(.MAX_BEATS(MAX_BEATS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_init_i  (bus_init_i),
   .xfer_beat_i (xfer_beat_i),
   .xfer_done_i (xfer_done_i),
   .grant_out_o (grant_out_o),
   .bus_req_o   (bus_req_o),
   .bus_ack_o   (bus_ack_o),
   .bus_own_o   (bus_own_o)
);

// File: tb/dma_chain_requester_tb.sv
`timescale 1ns/1ps
module dma_chain_requester_tb_top;

   localparam int SYNC = 2;
   localparam int MAXB = 5;
   localparam int HOLD = 2;
   localparam int DLY  = SYNC + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_init = 1'b0, want = 1'b0, beat = 1'b0, done = 1'b0;
   logic gin = 1'b0, busy = 1'b0;
   logic gout, breq, ack, own;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   dma_chain_requester #(.SYNC_STAGES(SYNC), .MAX_BEATS(MAXB), .HOLDOFF(HOLD)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_init_i(bus_init), .xfer_want_i(want),
      .xfer_beat_i(beat), .xfer_done_i(done), .grant_in_i(gin), .sync_busy_i(busy),
      .grant_out_o(gout), .bus_req_o(breq), .bus_ack_o(ack), .bus_own_o(own));

   function automatic bit exp_own_after(int beats_done, int cap);
      return beats_done < cap;
   endfunction

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(bit act, bit exp, string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      summary();
   end

   initial begin
      void'($urandom(32'h5a17c3));
      @(negedge clk);
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      chk(breq, 0, "R1 req"); chk(ack, 0, "R1 ack");
      chk(own, 0, "R1 own"); chk(gout, 0, "R1 gout");

      // R4 forward a grant when not requesting
      gin = 1'b1;
      tick(DLY - 1); chk(gout, 0, "R4 gout early");
      tick(1);       chk(gout, 1, "R4 gout rise");
      // R10 request raised mid-grant does not take it
      want = 1'b1;
      tick(1); chk(breq, 1, "R2 req rises");
      chk(gout, 1, "R10 still forwarded");
      tick(3); chk(ack, 0, "R10 no take"); chk(gout, 1, "R10 gout held");
      gin = 1'b0;
      tick(DLY - 1); chk(gout, 1, "R4 gout fall early");
      tick(1);       chk(gout, 0, "R4 gout fall");
      want = 1'b0;
      tick(2); chk(breq, 1, "R2 req persists");

      // R3 take with sync busy, R5 wait for sync release
      busy = 1'b1; gin = 1'b1;
      tick(DLY - 1); chk(breq, 1, "R3 req before take"); chk(ack, 0, "R3 ack early");
      tick(1); chk(breq, 0, "R3 req dropped"); chk(ack, 1, "R3 ack up");
      chk(gout, 0, "R3 gout low");
      tick(3); chk(own, 0, "R5 no own while busy"); chk(gout, 0, "R3 gout stays low");
      gin = 1'b0; busy = 1'b0;
      tick(DLY - 1); chk(own, 0, "R5 own early");
      tick(1);       chk(own, 1, "R5 own up");

      // R6 release on done, R8 hold-off
      beat = 1'b1; tick(1); beat = 1'b0; tick(1);
      chk(own, 1, "R7 below cap");
      want = 1'b1; done = 1'b1;
      tick(1); done = 1'b0;
      chk(own, 0, "R6 own drop"); chk(ack, 0, "R6 ack drop"); chk(breq, 0, "R8 quiet 0");
      tick(HOLD - 1); chk(breq, 0, "R8 quiet last");
      tick(1); chk(breq, 1, "R8 req after holdoff");

      // R7 beat cap, sync already low
      gin = 1'b1;
      tick(DLY); chk(ack, 1, "R3 ack up 2"); chk(own, 0, "R5 own one later");
      tick(1); chk(own, 1, "R5 own sync low");
      gin = 1'b0; want = 1'b0;
      beat = 1'b1;
      for (int b = 1; b <= MAXB; b++) begin
         tick(1);
         chk(own, exp_own_after(b, MAXB), "R7 cap");
      end
      beat = 1'b0;
      chk(ack, 0, "R7 ack drop");
      tick(HOLD + 1); chk(breq, 0, "R8 idle no want");

      // R9 bus reset during ownership
      want = 1'b1; tick(1); gin = 1'b1; tick(DLY + 1);
      chk(own, 1, "R9 owning before init");
      gin = 1'b0; tick(DLY);
      bus_init = 1'b1; want = 1'b0;
      tick(1); bus_init = 1'b0;
      chk(own, 0, "R9 own"); chk(ack, 0, "R9 ack");
      chk(breq, 0, "R9 req"); chk(gout, 0, "R9 gout");
      tick(2); chk(breq, 0, "R9 stays idle");

      // Random mix
      for (int it = 0; it < 40; it++) begin
         bit do_req;
         int sh;
         int n;
         do_req = 1'($urandom_range(0, 1));
         if (!do_req) begin
            gin = 1'b1; tick(DLY); chk(gout, 1, "R4 rnd rise");
            gin = 1'b0; tick(DLY); chk(gout, 0, "R4 rnd fall");
            tick($urandom_range(0, 3));
         end else begin
            want = 1'b1; tick(1); chk(breq, 1, "R2 rnd req");
            sh = $urandom_range(0, 3);
            busy = (sh != 0);
            gin = 1'b1; tick(DLY);
            chk(ack, 1, "R3 rnd ack"); chk(breq, 0, "R3 rnd req");
            gin = 1'b0; want = 1'b0;
            if (sh == 0) begin
               tick(1); chk(own, 1, "R5 rnd own");
            end else begin
               tick(sh); chk(own, 0, "R5 rnd busy");
               busy = 1'b0; tick(DLY); chk(own, 1, "R5 rnd own late");
            end
            n = $urandom_range(1, MAXB + 2);
            for (int b = 1; b <= n; b++) begin
               if (own) begin
                  beat = 1'b1; tick(1); beat = 1'b0;
                  chk(own, exp_own_after(b, MAXB), "R7 rnd beat");
                  if (own) tick($urandom_range(0, 2));
               end
            end
            if (own) begin
               done = 1'b1; tick(1); done = 1'b0;
               chk(own, 0, "R6 rnd done");
            end
            chk(ack, 0, "R6 rnd ack");
            tick(HOLD + 1);
         end
      end

      summary();
   end

endmodule